// File: doc/BRIEF.md
# Phase-Adjustable Bunch-Crossing Reset Pulse Generator

This block creates a periodic bunch-crossing reset (BCR) pulse for a group of downstream converter chips. It runs on the 40 MHz bunch clock and keeps an orbit counter of `ORBIT_LEN` slots (3564 by default). Once per orbit, each channel emits a pulse one clock period (25 ns) wide.

Each channel is presented as a 2-bit word per clock, ready for a serializer that runs at twice the clock rate (80 Mbps). Bit 1 of the word is shifted out first. Because of this, the pulse can be positioned in half-cycle (12.5 ns) steps by choosing which 2-bit words are sent, without any clock delay line.

Every channel has its own phase setting, in half-cycle units. A new setting takes effect only at an orbit boundary, so a change can never produce a doubled or missing pulse. A global enable forces every output word to zero. A synchronous restart realigns the orbit so that the next slot is slot 0.

Top module: `bcr_phase_gen`

## Requirements
- R1: While `rst_n` is low, every channel word is 2'b00. The first clock edge after reset release presents orbit slot 0 and samples the phase inputs, exactly as a restart would.
- R2: The internal orbit slot advances by one on every clock edge, from 0 to `ORBIT_LEN-1`, and then returns to 0. Each channel pattern therefore repeats every `ORBIT_LEN` cycles.
- R3: A clock edge that samples `restart` high presents slot 0 at that edge, regardless of the current slot.
- R4: For an even phase setting p below 2*`ORBIT_LEN`, the channel word is 2'b11 in slot p/2 and 2'b00 in every other slot. This is a full-width pulse, one cycle long.
- R5: For an odd phase setting p below 2*`ORBIT_LEN`, the channel sends 2'b01 in slot (p-1)/2 and 2'b10 in the following cycle. The 2'b10 word is sent in that cycle even when it falls in slot 0 of the next orbit, or in the cycle right after a restart. Both words are 2'b00 elsewhere, which yields a pulse delayed by half a cycle.
- R6: A channel's phase field, bits [ch*PH_W +: PH_W] of `phase_i`, is sampled only on an edge that presents slot 0. Changes at any other time do not affect the output.
- R7: An edge that samples `enable` low makes every channel word 2'b00 for that cycle. The orbit slot, the latched phases and any pending second half of a pulse keep advancing as if enabled.
- R8: A phase setting of 2*`ORBIT_LEN` or more produces no pulse; the channel word stays 2'b00 for the whole orbit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz bunch clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Global output enable |
| restart | input | 1 | Synchronous orbit restart; next slot is 0 |
| phase_i | input | NUM_CH*PH_W | Per-channel phase in half-cycle units, channel ch at [ch*PH_W +: PH_W] |
| pattern_o | output | NUM_CH*2 | Per-channel 2-bit word, channel ch at [ch*2 +: 2], bit 1 sent first |

## Verification
The bench sweeps every phase value of a 10-slot, 4-channel build, including the out-of-range values. Each case restarts at a different slot and compares every channel word on every cycle against a model derived from the requirements.

The hardest corner is an odd phase in the last slot. A design that computed the trailing 2'b10 from the slot index would drop it at the orbit wrap or after a restart, or would place it with the new phase. Changing the phases in the middle of an orbit exposes a design that loads them early, which shows up as a moved, doubled or missing pulse. Toggling the enable with an irregular pattern catches a design that stalls the orbit or loses the pending half-pulse while the outputs are gated.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam logic [1:0] PAT_IDLE = 2'b00;
    localparam logic [1:0] PAT_LATE = 2'b01;
    localparam logic [1:0] PAT_TAIL = 2'b10;
    localparam logic [1:0] PAT_FULL = 2'b11;
endpackage

// File: rtl/bcr_orbit_ctr.sv
module bcr_orbit_ctr #(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = $clog2(ORBIT_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] slot_next_o,
    output logic             wrap_next_o,
    output logic [CNT_W-1:0] slot_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] slot;
    } ctr_state_t;

    ctr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart || s_q.slot == LAST) begin
            s_d.slot = '0;
        end else begin
            s_d.slot = s_q.slot + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.slot <= LAST;
        end else begin
            s_q <= s_d;
        end
    end

    assign slot_next_o = s_d.slot;
    assign wrap_next_o = (s_d.slot == '0);
    assign slot_o      = s_q.slot;
endmodule

// File: rtl/bcr_chan.sv
module bcr_chan
    import bcr_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = $clog2(ORBIT_LEN),
    parameter int PH_W      = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load_i,
    input  logic [CNT_W-1:0] slot_next_i,
    input  logic [PH_W-1:0]  phase_i,
    output logic [1:0]       pat_o
);
    localparam logic [PH_W-1:0] PH_LIMIT = PH_W'(2 * ORBIT_LEN);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            late;
        logic [1:0]      pat;
    } chan_state_t;

    chan_state_t s_d, s_q;
    logic        hit;
    logic [1:0]  raw;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.phase = phase_i;
        end
        hit = (s_d.phase < PH_LIMIT) && (s_d.phase[PH_W-1:1] == slot_next_i);
        raw = PAT_IDLE;
        if (hit) begin
            raw = s_d.phase[0] ? PAT_LATE : PAT_FULL;
        end
        if (s_q.late) begin
            raw = raw | PAT_TAIL;
        end
        s_d.late = hit && s_d.phase[0];
        s_d.pat  = enable ? raw : PAT_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.phase <= '0;
            s_q.late  <= 1'b0;
            s_q.pat   <= PAT_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign pat_o = s_q.pat;
endmodule

// File: rtl/bcr_phase_gen.sv
module bcr_phase_gen #(
    parameter int NUM_CH    = 16,
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = $clog2(ORBIT_LEN),
    parameter int PH_W      = CNT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 restart,
    input  logic [NUM_CH*PH_W-1:0] phase_i,
    output logic [NUM_CH*2-1:0]  pattern_o
);
    logic [CNT_W-1:0] slot_next;
    logic [CNT_W-1:0] slot_q;
    logic             wrap_next;

    bcr_orbit_ctr #(
        .ORBIT_LEN(ORBIT_LEN),
        .CNT_W    (CNT_W)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .slot_next_o(slot_next),
        .wrap_next_o(wrap_next),
        .slot_o     (slot_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        bcr_chan #(
            .ORBIT_LEN(ORBIT_LEN),
            .CNT_W    (CNT_W),
            .PH_W     (PH_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (enable),
            .load_i     (wrap_next),
            .slot_next_i(slot_next),
            .phase_i    (phase_i[ch*PH_W +: PH_W]),
            .pat_o      (pattern_o[ch*2 +: 2])
        );
    end
endmodule

// File: rtl/bcr_phase_gen_chk.sv
module bcr_phase_gen_chk #(
    parameter int NUM_CH    = 16,
    parameter int ORBIT_LEN = 3564,
    parameter int CNT_W     = $clog2(ORBIT_LEN)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                restart,
    input logic [NUM_CH*2-1:0] pattern,
    input logic [CNT_W-1:0]    slot
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

    // R2: slot stays in range and steps by one
    a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= LAST);
    a_r2_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && slot != LAST) |=> slot == $past(slot) + CNT_W'(1));

    // R3: restart presents slot 0
    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> slot == '0);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // R4: a full pulse lasts one cycle only
        a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (pattern[ch*2 +: 2] == 2'b11 && !restart) |=> pattern[ch*2 +: 2] != 2'b11);
        // R5: a late first half is followed by the second half
        a_r5_tail_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (pattern[ch*2 +: 2] == 2'b01) |=> (pattern[ch*2 + 1] || !$past(enable)));
        // R7: disabled edge gives an idle word
        a_r7_gated_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> pattern[ch*2 +: 2] == 2'b00);
    end
endmodule

bind bcr_phase_gen bcr_phase_gen_chk #(
    .NUM_CH   (NUM_CH),
    .ORBIT_LEN(ORBIT_LEN),
    .CNT_W    (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .restart(restart),
    .pattern(pattern_o),
    .slot   (slot_q)
);

// File: tb/bcr_phase_gen_tb.sv
module bcr_phase_gen_tb;
    localparam int NCH  = 4;
    localparam int OL   = 10;
    localparam int CW   = $clog2(OL);
    localparam int PW   = CW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic restart = 1'b0;
    logic [NCH*PW-1:0] phase_i = '0;
    logic [NCH*2-1:0]  pattern_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m_slot;
    int m_phase [NCH];
    bit m_late  [NCH];
    int m_exp   [NCH];

    always #5 clk = ~clk;

    bcr_phase_gen #(.NUM_CH(NCH), .ORBIT_LEN(OL)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
        .phase_i(phase_i), .pattern_o(pattern_o)
    );

    task automatic check(input string req, input int ch, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s ch%0d slot %0d: got %0d expected %0d", req, ch, m_slot, act, exp);
        end
    endtask

    task automatic model_step();
        int raw;
        m_slot = (restart || m_slot == OL - 1) ? 0 : m_slot + 1;
        for (int ch = 0; ch < NCH; ch++) begin
            if (m_slot == 0) m_phase[ch] = int'(phase_i[ch*PW +: PW]);
            raw = 0;
            if (m_phase[ch] < 2 * OL && m_phase[ch] / 2 == m_slot)
                raw = (m_phase[ch] % 2 == 1) ? 1 : 3;
            if (m_late[ch]) raw = raw | 2;
            m_late[ch] = (m_phase[ch] < 2 * OL) && (m_phase[ch] / 2 == m_slot) && (m_phase[ch] % 2 == 1);
            m_exp[ch] = enable ? raw : 0;
        end
    endtask

    task automatic tick(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++)
            check(req, ch, int'(pattern_o[ch*2 +: 2]), m_exp[ch]);
    endtask

    task automatic set_phase(input int ch, input int p);
        phase_i[ch*PW +: PW] = PW'(p);
    endtask

    initial begin
        m_slot = OL - 1;
        for (int ch = 0; ch < NCH; ch++) begin
            m_phase[ch] = 0; m_late[ch] = 1'b0; m_exp[ch] = 0;
            set_phase(ch, 2 * ch + 1);
        end
        repeat (3) @(negedge clk);
        // R1: idle words during reset
        for (int ch = 0; ch < NCH; ch++)
            check("R1 reset", ch, int'(pattern_o[ch*2 +: 2]), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 2 * OL; k++) tick("R1 R2 first orbit after reset");

        // R4 R5 R8 R3: every phase value, restarts at varying slots
        for (int v = 0; v < 2 * OL + 4; v++) begin
            for (int ch = 0; ch < NCH; ch++)
                set_phase(ch, (v + ch * 7) % (2 * OL + 4));
            restart = 1'b1;
            tick("R3 restart");
            restart = 1'b0;
            for (int k = 0; k < 2 * OL + (v % OL); k++) tick("R4 R5 R8 R2 sweep");
        end

        // R5: odd phase in the last slot, wrap and restart right after it
        for (int ch = 0; ch < NCH; ch++) set_phase(ch, 2 * OL - 1 - 2 * ch);
        restart = 1'b1; tick("R3 restart");
        restart = 1'b0;
        for (int k = 0; k < OL + 2; k++) tick("R5 wrap tail");
        for (int k = 0; k < OL - 3; k++) tick("R5 wrap tail");
        restart = 1'b1; tick("R5 tail across restart");
        restart = 1'b0;
        for (int k = 0; k < OL; k++) tick("R5 tail across restart");

        // R6 R7: mid-orbit phase changes and irregular enable
        for (int k = 0; k < 8 * OL; k++) begin
            enable = (k % 3 != 1) && (k % 11 != 4);
            if (k % 7 == 3)
                for (int ch = 0; ch < NCH; ch++) set_phase(ch, (k + 5 * ch) % (2 * OL));
            tick("R6 R7 late change and gating");
        end
        enable = 1'b1;
        for (int k = 0; k < 2 * OL; k++) tick("R6 R7 recovery");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule